// File: doc/BRIEF.md
# Multiplexed-Address DRAM Sequencer with Row Refresh

The sequencer connects a single-request synchronous port to a DRAM device whose row and column addresses share one set of pins. Each request word address is cut into a row part (upper bits) and a column part (lower bits). The row part is driven while the row strobe falls and the column part while the column strobe falls. The output-enable strobe marks a read and the write-enable strobe marks a write.

After an access the addressed row stays open with the row strobe held low. A later request to the same row then needs only a column phase. A request to a different row first raises the row strobe for a precharge time and then opens the new row. A refresh timer raises a request once per programmable interval. The sequencer serves it before any new request, but only after the access in flight has finished. It closes the open row, strobes the next refresh row with the column strobe idle, and steps a wrapping row counter.

Top module: `dram_sequencer`

## Requirements
- R1: An accepted word address is split so that bits [ROW_W+COL_W-1:COL_W] are on the pins when the row strobe falls, and bits [COL_W-1:0] are on the pins when the column strobe falls. The column strobe never falls unless the row strobe was already low in the previous cycle.
- R2: A request whose row equals the open row starts a column phase directly. The port stays busy for exactly T_CAS cycles, and the row strobe does not rise.
- R3: With no row open (after reset or after a refresh), a request is busy for T_RCD+T_CAS cycles. A request to a different row than the open one is busy for T_PRE+T_RCD+T_CAS cycles and causes exactly one new fall of the row strobe.
- R4: In a read, output enable (active low) is low and write enable is high. In a write, the reverse holds. The two are never low together, and neither is low outside the column phase.
- R5: `req_ready` drops in the cycle after a request is accepted and returns high when the access ends. After a read, `rd_data` holds the word read. A write leaves `rd_data` unchanged.
- R6: A refresh is requested once every REF_INTERVAL cycles. Each refresh is a row-strobe-only cycle lasting exactly T_REF cycles with the column strobe high.
- R7: Refresh rows are issued in the order 0, 1, 2, … REF_ROWS-1 and then wrap to 0.
- R8: A due refresh blocks acceptance of new requests but does not cut short an access in flight. Every fall of the row strobe, whether for a refresh or for a new row, is preceded by at least T_PRE cycles with the row strobe high.
- R9: During and right after reset, `req_ready` is high and all four device strobes are high (inactive).
- R10: The column address on the pins stays stable for the whole column phase, and the column strobe is low only while the row strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Port idle; a request with req_valid is taken at this edge |
| rd_data | output | DATA_W | Last word read |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_oe_n | output | 1 | Output enable (read), active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_wdata | output | DATA_W | Data driven to the device |
| dram_rdata | input | DATA_W | Data returned by the device |

## Verification
Suppose the sequencer's idea of the open row diverges from what the device latched. The next same-row request would then show the wrong busy length on `req_ready` within a few cycles, and its read data would come from the wrong row. A refresh counter that skips a row or fails to wrap shows up at the very next refresh, because the strobed row no longer follows the expected sequence. A stuck phase counter shows up as an access latency or a refresh strobe width that no longer matches the parameters. Strobe overlaps and address changes during a column phase are caught in the same cycle.

// File: rtl/dramc_pkg.sv
// Shared types for the DRAM sequencer.
// Assumes: no parameters needed here; widths are set in the modules.
package dramc_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_COL,
        ST_REF
    } seq_state_e;

    // Source of the shared address pins
    typedef enum logic [1:0] {
        PIN_ROW,
        PIN_COL,
        PIN_REF
    } pin_sel_e;

    // Phase that follows a precharge
    typedef enum logic [1:0] {
        NXT_ROW,
        NXT_REF,
        NXT_IDLE
    } pre_next_e;

endpackage

// File: rtl/dramc_refresh_sched.sv
// Refresh scheduler: raises ref_due once every INTERVAL cycles and holds
// it until the sequencer reports a finished refresh. It also supplies the
// row to refresh, which steps by one per refresh and wraps after ROWS-1.
// Assumes: INTERVAL >= 2, 1 <= ROWS <= 2**ROW_W.
module dramc_refresh_sched #(
    parameter int INTERVAL = 2400,
    parameter int ROWS     = 2048,
    parameter int ROW_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_done,
    output logic             ref_due,
    output logic [ROW_W-1:0] ref_row
);
    localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] tick_cnt;
    logic          tick;

    assign tick = (tick_cnt == TW'(INTERVAL - 1));

    // Free-running interval counter
    always_ff @(posedge clk) begin
        if (!rst_n)    tick_cnt <= '0;
        else if (tick) tick_cnt <= '0;
        else           tick_cnt <= tick_cnt + 1'b1;
    end

    // Pending flag: set by the interval tick, cleared by a completed refresh
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_due <= 1'b0;
        else if (tick)     ref_due <= 1'b1;
        else if (ref_done) ref_due <= 1'b0;
    end

    // Refresh row pointer with wrap at the last row
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_row <= '0;
        else if (ref_done)
            ref_row <= (ref_row == ROW_W'(ROWS - 1)) ? '0 : ref_row + 1'b1;
    end

endmodule

// File: rtl/dramc_addr_path.sv
// Address path: latches the split request address, remembers which row
// is open in the device, flags a row hit, and drives the shared pins.
// Assumes: accept, open_set and open_clear come from the sequencer FSM.
module dramc_addr_path
    import dramc_pkg::*;
#(
    parameter int ROW_W = 11,
    parameter int COL_W = 11,
    parameter int PIN_W = 11
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic                   open_set,
    input  logic                   open_clear,
    input  pin_sel_e               pin_sel,
    input  logic [ROW_W-1:0]       ref_row,
    output logic                   row_hit,
    output logic                   row_open,
    output logic [PIN_W-1:0]       dram_addr
);
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] open_row;
    logic [ROW_W-1:0] req_row;

    assign req_row = req_addr[ROW_W+COL_W-1:COL_W];

    // Capture the two halves of an accepted address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else if (accept) begin
            row_q <= req_row;
            col_q <= req_addr[COL_W-1:0];
        end
    end

    // Track the row currently held open in the device
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_row <= '0;
            row_open <= 1'b0;
        end else if (open_set) begin
            open_row <= row_q;
            row_open <= 1'b1;
        end else if (open_clear) begin
            row_open <= 1'b0;
        end
    end

    // Same-row detection on the incoming request
    assign row_hit = row_open && (req_row == open_row);

    // Shared pin multiplexer
    always_comb begin
        case (pin_sel)
            PIN_COL: dram_addr = PIN_W'(col_q);
            PIN_REF: dram_addr = PIN_W'(ref_row);
            default: dram_addr = PIN_W'(row_q);
        endcase
    end

endmodule

// File: rtl/dramc_seq_fsm.sv
// Strobe sequencer: accepts requests, runs the precharge, row and column
// phases with per-phase cycle counters, inserts refresh cycles, and
// captures read data at the last column cycle.
// Assumes: all phase times are at least 1 cycle.
module dramc_seq_fsm
    import dramc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int T_PRE  = 1,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_REF  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              row_hit,
    input  logic              row_open,
    input  logic              ref_due,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              accept,
    output logic              open_set,
    output logic              open_clear,
    output logic              ref_done,
    output pin_sel_e          pin_sel,
    output logic              ras_n,
    output logic              cas_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [DATA_W-1:0] dram_wdata
);
    localparam int T_A   = (T_PRE > T_RCD) ? T_PRE : T_RCD;
    localparam int T_B   = (T_CAS > T_REF) ? T_CAS : T_REF;
    localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
    localparam int CW    = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    seq_state_e        state;
    pre_next_e         nxt;
    logic [CW-1:0]     cnt;
    logic              wr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              last;

    assign last      = (cnt == '0);
    assign req_ready = (state == ST_IDLE) && !ref_due;
    assign accept    = req_ready && req_valid;

    // Phase transitions and phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            nxt   <= NXT_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ref_due) begin
                        state <= ST_PRE;
                        nxt   <= NXT_REF;
                        cnt   <= CW'(T_PRE - 1);
                    end else if (req_valid) begin
                        if (row_hit) begin
                            state <= ST_COL;
                            cnt   <= CW'(T_CAS - 1);
                        end else if (row_open) begin
                            state <= ST_PRE;
                            nxt   <= NXT_ROW;
                            cnt   <= CW'(T_PRE - 1);
                        end else begin
                            state <= ST_ROW;
                            cnt   <= CW'(T_RCD - 1);
                        end
                    end
                end
                ST_PRE: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        case (nxt)
                            NXT_ROW: begin
                                state <= ST_ROW;
                                cnt   <= CW'(T_RCD - 1);
                            end
                            NXT_REF: begin
                                state <= ST_REF;
                                cnt   <= CW'(T_REF - 1);
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_ROW: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        state <= ST_COL;
                        cnt   <= CW'(T_CAS - 1);
                    end
                end
                ST_COL: begin
                    if (!last) cnt <= cnt - 1'b1;
                    else       state <= ST_IDLE;
                end
                ST_REF: begin
                    if (!last) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        state <= ST_PRE;
                        nxt   <= NXT_IDLE;
                        cnt   <= CW'(T_PRE - 1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request attributes held for the duration of the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Read data capture on the final column cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (state == ST_COL && last && !wr_q)
            rd_data <= dram_rdata;
    end

    // Row-tracking and refresh handshakes toward the neighbours
    assign open_set   = (state == ST_ROW) && last;
    assign open_clear = (state == ST_IDLE) &&
                        (ref_due || (req_valid && row_open && !row_hit));
    assign ref_done   = (state == ST_REF) && last;

    // Strobes and pin source decoded from the phase
    always_comb begin
        ras_n   = !((state == ST_ROW) || (state == ST_COL) ||
                    (state == ST_REF) || ((state == ST_IDLE) && row_open));
        cas_n   = (state != ST_COL);
        oe_n    = !((state == ST_COL) && !wr_q);
        we_n    = !((state == ST_COL) && wr_q);
        pin_sel = (state == ST_REF) ? PIN_REF :
                  (state == ST_COL) ? PIN_COL : PIN_ROW;
    end

    assign dram_wdata = wdata_q;

endmodule

// File: rtl/dram_sequencer.sv
// Top level: DRAM sequencer with open-row reuse and periodic row refresh.
// Assumes: a device with multiplexed row/column pins and active-low
// strobes; one request in flight at a time.
module dram_sequencer
    import dramc_pkg::*;
#(
    parameter int ROW_W        = 11,
    parameter int COL_W        = 11,
    parameter int DATA_W       = 16,
    parameter int T_PRE        = 1,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_REF        = 3,
    parameter int REF_INTERVAL = 2400,
    parameter int REF_ROWS     = 2048,
    localparam int ADDR_W      = ROW_W + COL_W,
    localparam int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic [PIN_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_oe_n,
    output logic              dram_we_n,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);
    logic             accept;
    logic             open_set;
    logic             open_clear;
    logic             ref_done;
    logic             ref_due;
    logic             row_hit;
    logic             row_open;
    logic [ROW_W-1:0] ref_row;
    pin_sel_e         pin_sel;

    dramc_refresh_sched #(
        .INTERVAL(REF_INTERVAL),
        .ROWS    (REF_ROWS),
        .ROW_W   (ROW_W)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_done(ref_done),
        .ref_due (ref_due),
        .ref_row (ref_row)
    );

    dramc_addr_path #(
        .ROW_W(ROW_W),
        .COL_W(COL_W),
        .PIN_W(PIN_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .open_set  (open_set),
        .open_clear(open_clear),
        .pin_sel   (pin_sel),
        .ref_row   (ref_row),
        .row_hit   (row_hit),
        .row_open  (row_open),
        .dram_addr (dram_addr)
    );

    dramc_seq_fsm #(
        .DATA_W(DATA_W),
        .T_PRE (T_PRE),
        .T_RCD (T_RCD),
        .T_CAS (T_CAS),
        .T_REF (T_REF)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .row_hit   (row_hit),
        .row_open  (row_open),
        .ref_due   (ref_due),
        .dram_rdata(dram_rdata),
        .req_ready (req_ready),
        .rd_data   (rd_data),
        .accept    (accept),
        .open_set  (open_set),
        .open_clear(open_clear),
        .ref_done  (ref_done),
        .pin_sel   (pin_sel),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .oe_n      (dram_oe_n),
        .we_n      (dram_we_n),
        .dram_wdata(dram_wdata)
    );

endmodule

// File: rtl/dramc_sva.sv
// Protocol checker for the DRAM sequencer, attached by bind.
// Assumes: synchronous active-low reset held from time zero.
module dramc_sva #(
    parameter int PIN_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             ras_n,
    input logic             cas_n,
    input logic             oe_n,
    input logic             we_n,
    input logic [PIN_W-1:0] addr
);
    // Read and write enables are mutually exclusive
    assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // Data enables only inside a column phase
    assert_enable_in_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !cas_n);

    // Column strobe only inside an open row
    assert_cas_inside_row_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // Column address held through the column phase
    assert_col_addr_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(addr));

    // Row phase precedes each column phase
    assert_row_before_col_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!ras_n));

    // Port goes busy after acceptance
    assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind dram_sequencer dramc_sva #(.PIN_W(PIN_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .ras_n    (dram_ras_n),
    .cas_n    (dram_cas_n),
    .oe_n     (dram_oe_n),
    .we_n     (dram_we_n),
    .addr     (dram_addr)
);

// File: tb/test_dram_sequencer.sv
// Directed bench for dram_sequencer with a behavioural DRAM model.
module test_dram_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W  = 11;
    localparam int COL_W  = 11;
    localparam int DATA_W = 16;
    localparam int T_PRE  = 1;
    localparam int T_RCD  = 2;
    localparam int T_CAS  = 2;
    localparam int T_REF  = 3;
    localparam int REF_INTERVAL = 60;
    localparam int REF_ROWS     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [21:0]       req_addr = '0;
    logic [15:0]       req_wdata = '0;
    logic              req_ready;
    logic [15:0]       rd_data;
    logic [10:0]       dram_addr;
    logic              dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n;
    logic [15:0]       dram_wdata;
    logic [15:0]       dram_rdata;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_sequencer #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_REF(T_REF),
        .REF_INTERVAL(REF_INTERVAL), .REF_ROWS(REF_ROWS)
    ) i_dram_sequencer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_oe_n(dram_oe_n),
        .dram_we_n(dram_we_n), .dram_wdata(dram_wdata),
        .dram_rdata(dram_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural device model ----------------
    logic [15:0] mem [0:127];
    logic [10:0] m_row = '0;
    logic [10:0] m_col = '0;
    bit  prev_ras = 1'b1, prev_cas = 1'b1, cas_seen = 1'b0;
    int  high_run = 100, low_run = 0;
    int  ras_falls = 0, ref_count = 0, exp_ref_row = 0;
    int  oe_cycles = 0, we_cycles = 0;

    initial for (int i = 0; i < 128; i++) mem[i] = '0;

    assign dram_rdata = (!dram_oe_n && !dram_cas_n) ? mem[{m_row[2:0], dram_addr[3:0]}] : 16'hDEAD;

    // Sample device pins between clock edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !dram_ras_n) begin
                m_row = dram_addr;
                ras_falls++;
                cas_seen = 1'b0;
                low_run = 0;
                check(high_run >= T_PRE, "R8 precharge before row strobe", high_run, T_PRE);
            end
            if (!dram_ras_n) begin
                low_run++;
                high_run = 0;
            end else begin
                high_run++;
            end
            if (!dram_cas_n) begin
                cas_seen = 1'b1;
                if (prev_cas) m_col = dram_addr;
                if (!dram_we_n) mem[{m_row[2:0], dram_addr[3:0]}] = dram_wdata;
            end
            if (!dram_oe_n) oe_cycles++;
            if (!dram_we_n) we_cycles++;
            if (!prev_ras && dram_ras_n && !cas_seen) begin
                check(m_row == 11'(exp_ref_row), "R7 refresh row order", int'(m_row), exp_ref_row);
                check(low_run == T_REF, "R6 refresh strobe width", low_run, T_REF);
                exp_ref_row = (exp_ref_row + 1) % REF_ROWS;
                ref_count++;
            end
            prev_ras = dram_ras_n;
            prev_cas = dram_cas_n;
        end
    end

    // ---------------- helpers ----------------
    task automatic access(input logic wr, input logic [21:0] a, input logic [15:0] d, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!req_ready) begin
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic sync_refresh();
        int start = ref_count;
        while (ref_count == start) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready in reset", int'(req_ready), 1);
        check({dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n} === 4'hF, "R9 strobes idle",
              int'({dram_ras_n, dram_cas_n, dram_oe_n, dram_we_n}), 15);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1, "R9 ready after reset", int'(req_ready), 1);
        check(dram_ras_n === 1'b1, "R9 row strobe after reset", int'(dram_ras_n), 1);
    endtask

    task automatic t_row_reuse();
        int lat, falls, oe0, we0;
        logic [15:0] keep;
        sync_refresh();
        falls = ras_falls;
        access(1'b1, {11'd1, 11'd3}, 16'hA1A1, lat);
        check(lat == T_RCD + T_CAS, "R3 closed-row latency", lat, T_RCD + T_CAS);
        check(m_row == 11'd1, "R1 row half on pins", int'(m_row), 1);
        check(m_col == 11'd3, "R1 column half on pins", int'(m_col), 3);
        check(ras_falls == falls + 1, "R3 one row open", ras_falls - falls, 1);
        falls = ras_falls;
        oe0 = oe_cycles; we0 = we_cycles;
        access(1'b1, {11'd1, 11'd5}, 16'hB2B2, lat);
        check(lat == T_CAS, "R2 row hit latency", lat, T_CAS);
        check(ras_falls == falls, "R2 no new row strobe", ras_falls - falls, 0);
        check(m_col == 11'd5, "R1 column of second access", int'(m_col), 5);
        check(we_cycles - we0 == T_CAS && oe_cycles == oe0, "R4 write uses write enable only",
              we_cycles - we0, T_CAS);
        oe0 = oe_cycles; we0 = we_cycles;
        access(1'b0, {11'd1, 11'd3}, 16'h0, lat);
        check(lat == T_CAS, "R2 row hit read latency", lat, T_CAS);
        check(rd_data == 16'hA1A1, "R5 read data", int'(rd_data), 'hA1A1);
        check(oe_cycles - oe0 == T_CAS && we_cycles == we0, "R4 read uses output enable only",
              oe_cycles - oe0, T_CAS);
        keep = rd_data;
        falls = ras_falls;
        access(1'b1, {11'd2, 11'd3}, 16'hC3C3, lat);
        check(lat == T_PRE + T_RCD + T_CAS, "R3 row miss latency", lat, T_PRE + T_RCD + T_CAS);
        check(ras_falls == falls + 1, "R3 single reopen", ras_falls - falls, 1);
        check(rd_data == keep, "R5 write leaves read data", int'(rd_data), int'(keep));
        access(1'b0, {11'd1, 11'd5}, 16'h0, lat);
        check(lat == T_PRE + T_RCD + T_CAS, "R3 miss back to row 1", lat, T_PRE + T_RCD + T_CAS);
        check(rd_data == 16'hB2B2, "R5 read after miss", int'(rd_data), 'hB2B2);
        sync_refresh();
        access(1'b0, {11'd2, 11'd3}, 16'h0, lat);
        check(lat == T_RCD + T_CAS, "R3 latency after refresh", lat, T_RCD + T_CAS);
        check(rd_data == 16'hC3C3, "R5 data survives refresh", int'(rd_data), 'hC3C3);
    endtask

    task automatic t_refresh_rate();
        int c0 = ref_count;
        repeat (600) @(negedge clk);
        check(ref_count - c0 >= 9 && ref_count - c0 <= 11, "R6 refresh rate in idle",
              ref_count - c0, 10);
    endtask

    task automatic t_stress();
        int lat, c0, cyc;
        c0 = ref_count;
        cyc = 0;
        for (int i = 0; i < 24; i++) begin
            access(1'b1, {11'(3 + i % 2), 11'(i / 2)}, 16'(16'h5000 + i), lat);
            cyc += lat + 2;
        end
        for (int i = 0; i < 24; i++) begin
            access(1'b0, {11'(3 + i % 2), 11'(i / 2)}, 16'h0, lat);
            cyc += lat + 2;
            check(rd_data == 16'(16'h5000 + i), "R8 data under refresh interleave",
                  int'(rd_data), 'h5000 + i);
        end
        check(ref_count - c0 >= cyc / REF_INTERVAL - 1, "R8 refresh not starved by traffic",
              ref_count - c0, cyc / REF_INTERVAL);
        check(ref_count > REF_ROWS, "R7 refresh counter wrapped", ref_count, REF_ROWS + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_row_reuse();
        t_refresh_rate();
        t_stress();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule